// File: doc/BRIEF.md
# Filter-Steered Receive Buffer Writer

This block stores an already assembled CAN receive message into a region of RAM divided into equal message buffers of eight 16-bit words each. Alongside the message it is given the number of the acceptance filter (0 to 15) that recognised the identifier. Each filter owns a 4-bit buffer pointer. The filter's pointer names the destination buffer, so the write address depends on which filter matched rather than on a rolling index.

A small write-only configuration port holds the sixteen pointers, a 3-bit buffer-count code, the region base address and an interrupt word threshold. An accepted message is written one word per cycle to consecutive addresses starting at base + 8 × pointer. A word counter raises a one-cycle interrupt each time the programmed number of words has been stored. A message whose pointer lies outside the configured buffer count is discarded and recorded in a sticky flag. A message that arrives while a write is in flight is also discarded and recorded in a second sticky flag.

Configuration map (cfg_addr): 0 to 15 hold the pointer of filter n in cfg_wdata[3:0]; 16 holds the count code in cfg_wdata[2:0]; 17 holds the base address in cfg_wdata[11:0]; 18 holds the interrupt word threshold in cfg_wdata[15:0].

Top module: `canrx_steer_writer`

## Requirements
- R1: Synchronous active-high reset clears all pointers, the base address and the threshold to 0, selects count code 000, and clears the word counter, irq, busy, ram_we and both sticky flags.
- R2: An accepted message from filter n is written to addresses base + 8 × pointer[n] + w for w = 0..7, using the pointer value held at the accepting edge.
- R3: The eight words are written in ascending order, one per cycle, on the eight cycles that follow the accepting clock edge; word w is taken from msg_words[16w+15:16w].
- R4: The count code maps as 000=4, 001=6, 010=8, 011=12, 100=16, 101=24, 110=32 and 111=32 buffers.
- R5: A message whose pointer is at or above the buffer count causes no RAM write and sets drop_flag, which stays set until reset.
- R6: msg_valid while busy is ignored: the write in flight completes unchanged and miss_flag is set until reset.
- R7: busy is high for exactly the eight write cycles of an accepted message. A message is accepted only when busy is low.
- R8: With threshold N > 0, irq pulses for one cycle in the cycle after every N-th word write, counted since reset or since the previous pulse. The counter then restarts from zero.
- R9: A threshold of 0 disables irq and holds the word counter at zero.
- R10: Configuration writes made during a message's write cycles do not change that message's addresses or data.
- R11: Addresses wrap modulo 2^12, so a buffer that straddles the top of the address space continues at address 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 5 | Configuration register select |
| cfg_wdata | input | 16 | Configuration write data |
| msg_valid | input | 1 | A matched message is presented this cycle |
| msg_filter | input | 4 | Number of the filter that matched |
| msg_words | input | 128 | Eight message words, word w at bits 16w+15:16w |
| ram_we | output | 1 | RAM write strobe |
| ram_addr | output | 12 | RAM word address |
| ram_wdata | output | 16 | RAM write data |
| busy | output | 1 | A message is being written |
| irq | output | 1 | One-cycle word-count interrupt |
| drop_flag | output | 1 | Sticky: a message pointed past the buffer count |
| miss_flag | output | 1 | Sticky: a message arrived while busy |

## Verification
Two situations are hard to reach from the ports. The first is a collision between a new match and the last write cycle of the previous message. The second is a configuration change landing in the middle of a write. The stimulus presents messages on consecutive cycles and writes pointers and the base address while busy is high. A behavioural model, driven by the same inputs, predicts every RAM write and every irq pulse. The count-code boundaries are reached by placing a pointer just below and just at each count. Interrupt thresholds of 1, 3, 8 and 0 are used so that pulses fall both inside and at the end of a message.

// File: rtl/canrx_pkg.sv
package canrx_pkg;

  // Number of message buffers selected by the 3-bit count code.
  function automatic int unsigned size_to_count(input logic [2:0] code);
    case (code)
      3'd0:    return 4;
      3'd1:    return 6;
      3'd2:    return 8;
      3'd3:    return 12;
      3'd4:    return 16;
      3'd5:    return 24;
      default: return 32;
    endcase
  endfunction

  // First word address of a buffer, before truncation to the address width.
  function automatic logic [31:0] buffer_start(input logic [31:0] base,
                                               input logic [31:0] idx,
                                               input int unsigned words);
    return base + idx * words;
  endfunction

endpackage

// File: rtl/canrx_cfg_regs.sv
module canrx_cfg_regs #(
  parameter int NFILT   = 16,
  parameter int PTR_W   = 4,
  parameter int AW      = 12,
  parameter int CNT_W   = 16,
  parameter int CFG_DW  = 16,
  parameter int COUNT_W = 6,
  localparam int CFG_AW = $clog2(NFILT + 3),
  localparam int FILT_W = $clog2(NFILT)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               cfg_we,
  input  logic [CFG_AW-1:0]  cfg_addr,
  input  logic [CFG_DW-1:0]  cfg_wdata,
  input  logic [FILT_W-1:0]  lookup_idx,
  output logic [PTR_W-1:0]   lookup_ptr,
  output logic [COUNT_W-1:0] buf_count,
  output logic [AW-1:0]      base_addr,
  output logic [CNT_W-1:0]   irq_thresh
);
  import canrx_pkg::*;

  localparam int REG_SIZE = NFILT;
  localparam int REG_BASE = NFILT + 1;
  localparam int REG_THR  = NFILT + 2;

  logic [PTR_W-1:0] ptr_q [NFILT];
  logic [2:0]       size_q;

  for (genvar g = 0; g < NFILT; g++) begin : g_ptr
    always_ff @(posedge clk) begin
      if (rst)
        ptr_q[g] <= '0;
      else if (cfg_we && cfg_addr == CFG_AW'(g))
        ptr_q[g] <= cfg_wdata[PTR_W-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      size_q     <= 3'd0;
      base_addr  <= '0;
      irq_thresh <= '0;
    end else if (cfg_we) begin
      if (cfg_addr == CFG_AW'(REG_SIZE)) size_q     <= cfg_wdata[2:0];
      if (cfg_addr == CFG_AW'(REG_BASE)) base_addr  <= cfg_wdata[AW-1:0];
      if (cfg_addr == CFG_AW'(REG_THR))  irq_thresh <= cfg_wdata[CNT_W-1:0];
    end
  end

  assign lookup_ptr = ptr_q[lookup_idx];
  assign buf_count  = COUNT_W'(size_to_count(size_q));

  a_r4_count_legal: assert property (@(posedge clk) disable iff (rst)
    (buf_count >= COUNT_W'(4)) && (buf_count <= COUNT_W'(32)));

endmodule

// File: rtl/canrx_write_seq.sv
module canrx_write_seq #(
  parameter int PTR_W   = 4,
  parameter int AW      = 12,
  parameter int DW      = 16,
  parameter int WORDS   = 8,
  parameter int COUNT_W = 6,
  localparam int WIDX_W = $clog2(WORDS)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               msg_valid,
  input  logic [WORDS*DW-1:0] msg_words,
  input  logic [PTR_W-1:0]   lookup_ptr,
  input  logic [COUNT_W-1:0] buf_count,
  input  logic [AW-1:0]      base_addr,
  output logic               ram_we,
  output logic [AW-1:0]      ram_addr,
  output logic [DW-1:0]      ram_wdata,
  output logic               busy,
  output logic               drop_flag,
  output logic               miss_flag,
  output logic               wr_evt
);
  import canrx_pkg::*;

  logic              active;
  logic [WIDX_W-1:0] wcnt;
  logic [AW-1:0]     start_q;
  logic [DW-1:0]     words_q [WORDS];

  // Named events for the assertions.
  logic ptr_ok, accept_evt, drop_evt, miss_evt, last_evt;
  logic [AW-1:0] start_d;

  assign ptr_ok     = COUNT_W'(lookup_ptr) < buf_count;
  assign accept_evt = msg_valid && !active && ptr_ok;
  assign drop_evt   = msg_valid && !active && !ptr_ok;
  assign miss_evt   = msg_valid && active;
  assign last_evt   = active && (wcnt == WIDX_W'(WORDS - 1));
  assign start_d    = AW'(buffer_start(32'(base_addr), 32'(lookup_ptr), WORDS));

  always_ff @(posedge clk) begin
    if (rst) begin
      active  <= 1'b0;
      wcnt    <= '0;
      start_q <= '0;
    end else if (accept_evt) begin
      active  <= 1'b1;
      wcnt    <= '0;
      start_q <= start_d;
    end else if (active) begin
      wcnt <= wcnt + 1'b1;
      if (last_evt) active <= 1'b0;
    end
  end

  for (genvar w = 0; w < WORDS; w++) begin : g_word
    always_ff @(posedge clk) begin
      if (rst)
        words_q[w] <= '0;
      else if (accept_evt)
        words_q[w] <= msg_words[w*DW +: DW];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      drop_flag <= 1'b0;
      miss_flag <= 1'b0;
    end else begin
      if (drop_evt) drop_flag <= 1'b1;
      if (miss_evt) miss_flag <= 1'b1;
    end
  end

  assign busy      = active;
  assign ram_we    = active;
  assign wr_evt    = active;
  assign ram_addr  = start_q + AW'(wcnt);
  assign ram_wdata = words_q[wcnt];

  a_r3_addr_step: assert property (@(posedge clk) disable iff (rst)
    (ram_we && $past(ram_we) && wcnt != '0) |-> ram_addr == $past(ram_addr) + 1'b1);

  a_r3_first_word: assert property (@(posedge clk) disable iff (rst)
    accept_evt |=> (busy && wcnt == '0));

  a_r5_drop_no_write: assert property (@(posedge clk) disable iff (rst)
    drop_evt |=> !ram_we);

  a_r6_miss_keeps_target: assert property (@(posedge clk) disable iff (rst)
    miss_evt |=> start_q == $past(start_q));

  a_r7_idle_after_last: assert property (@(posedge clk) disable iff (rst)
    last_evt |=> !busy);

  a_r5_flag_sticky: assert property (@(posedge clk) disable iff (rst)
    $past(drop_flag) |-> drop_flag);

endmodule

// File: rtl/canrx_irq_ctr.sv
module canrx_irq_ctr #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_evt,
  input  logic [CNT_W-1:0] thresh,
  output logic             irq
);
  logic [CNT_W-1:0] cnt;
  logic [CNT_W:0]   cnt_next;
  logic             reach;

  assign cnt_next = {1'b0, cnt} + 1'b1;
  assign reach    = cnt_next >= {1'b0, thresh};

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
      irq <= 1'b0;
    end else begin
      irq <= 1'b0;
      if (thresh == '0) begin
        cnt <= '0;
      end else if (wr_evt) begin
        if (reach) begin
          cnt <= '0;
          irq <= 1'b1;
        end else begin
          cnt <= cnt_next[CNT_W-1:0];
        end
      end
    end
  end

  a_r8_irq_after_write: assert property (@(posedge clk) disable iff (rst)
    irq |-> $past(wr_evt));

  a_r9_irq_needs_thresh: assert property (@(posedge clk) disable iff (rst)
    irq |-> $past(thresh) != '0);

endmodule

// File: rtl/canrx_steer_writer.sv
module canrx_steer_writer #(
  parameter int NFILT  = 16,
  parameter int PTR_W  = 4,
  parameter int AW     = 12,
  parameter int DW     = 16,
  parameter int WORDS  = 8,
  parameter int CNT_W  = 16,
  parameter int CFG_DW = 16,
  localparam int CFG_AW = $clog2(NFILT + 3),
  localparam int FILT_W = $clog2(NFILT)
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                cfg_we,
  input  logic [CFG_AW-1:0]   cfg_addr,
  input  logic [CFG_DW-1:0]   cfg_wdata,
  input  logic                msg_valid,
  input  logic [FILT_W-1:0]   msg_filter,
  input  logic [WORDS*DW-1:0] msg_words,
  output logic                ram_we,
  output logic [AW-1:0]       ram_addr,
  output logic [DW-1:0]       ram_wdata,
  output logic                busy,
  output logic                irq,
  output logic                drop_flag,
  output logic                miss_flag
);
  localparam int COUNT_W = 6;

  logic [PTR_W-1:0]   lookup_ptr;
  logic [COUNT_W-1:0] buf_count;
  logic [AW-1:0]      base_addr;
  logic [CNT_W-1:0]   irq_thresh;
  logic               wr_evt;

  canrx_cfg_regs #(
    .NFILT(NFILT), .PTR_W(PTR_W), .AW(AW), .CNT_W(CNT_W),
    .CFG_DW(CFG_DW), .COUNT_W(COUNT_W)
  ) u_cfg (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .lookup_idx(msg_filter), .lookup_ptr(lookup_ptr),
    .buf_count(buf_count), .base_addr(base_addr), .irq_thresh(irq_thresh)
  );

  canrx_write_seq #(
    .PTR_W(PTR_W), .AW(AW), .DW(DW), .WORDS(WORDS), .COUNT_W(COUNT_W)
  ) u_seq (
    .clk(clk), .rst(rst), .msg_valid(msg_valid), .msg_words(msg_words),
    .lookup_ptr(lookup_ptr), .buf_count(buf_count), .base_addr(base_addr),
    .ram_we(ram_we), .ram_addr(ram_addr), .ram_wdata(ram_wdata), .busy(busy),
    .drop_flag(drop_flag), .miss_flag(miss_flag), .wr_evt(wr_evt)
  );

  canrx_irq_ctr #(.CNT_W(CNT_W)) u_irq (
    .clk(clk), .rst(rst), .wr_evt(wr_evt), .thresh(irq_thresh), .irq(irq)
  );

  a_r1_quiet_after_reset: assert property (@(posedge clk)
    $past(rst) |-> (!ram_we && !busy && !irq && !drop_flag && !miss_flag));

endmodule

// File: tb/sim_canrx_steer_writer.sv
module sim_canrx_steer_writer;
  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         cfg_we = 1'b0;
  logic [4:0]   cfg_addr = '0;
  logic [15:0]  cfg_wdata = '0;
  logic         msg_valid = 1'b0;
  logic [3:0]   msg_filter = '0;
  logic [127:0] msg_words = '0;
  logic         ram_we, busy, irq, drop_flag, miss_flag;
  logic [11:0]  ram_addr;
  logic [15:0]  ram_wdata;

  always #4 clk = ~clk;

  canrx_steer_writer u0 (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .msg_valid(msg_valid), .msg_filter(msg_filter),
    .msg_words(msg_words), .ram_we(ram_we), .ram_addr(ram_addr),
    .ram_wdata(ram_wdata), .busy(busy), .irq(irq), .drop_flag(drop_flag),
    .miss_flag(miss_flag)
  );

  int checks = 0;
  int failures = 0;
  int cyc = 0;
  bit done = 0;
  string scen = "R1";
  int irq_seen = 0;
  int seqn = 0;

  // Behavioural reference model.
  int m_aq[$];
  int m_dq[$];
  int m_ptr[16];
  int m_size, m_base, m_thr, m_wc;
  bit m_irq, m_drop, m_miss;
  int sizes[8] = '{4, 6, 8, 12, 16, 24, 32, 32};

  task automatic chk(input string tag, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s [%s] %s act=%0d exp=%0d", tag, scen, what, act, exp);
    end
  endtask

  always @(posedge clk) begin
    if (rst) begin
      m_aq.delete(); m_dq.delete();
      foreach (m_ptr[i]) m_ptr[i] = 0;
      m_size = 0; m_base = 0; m_thr = 0; m_wc = 0;
      m_irq = 0; m_drop = 0; m_miss = 0;
    end else begin
      bit was_busy;
      was_busy = (m_aq.size() != 0);
      m_irq = 0;
      if (was_busy) begin
        void'(m_aq.pop_front());
        void'(m_dq.pop_front());
      end
      if (m_thr == 0) m_wc = 0;
      else if (was_busy) begin
        m_wc++;
        if (m_wc >= m_thr) begin m_wc = 0; m_irq = 1; end
      end
      if (msg_valid) begin
        int p;
        p = m_ptr[msg_filter];
        if (was_busy) m_miss = 1;
        else if (p >= sizes[m_size]) m_drop = 1;
        else for (int w = 0; w < 8; w++) begin
          m_aq.push_back((m_base + p * 8 + w) % 4096);
          m_dq.push_back(int'(msg_words[w*16 +: 16]));
        end
      end
      if (cfg_we) begin
        if (cfg_addr < 16) m_ptr[cfg_addr] = int'(cfg_wdata[3:0]);
        else if (cfg_addr == 16) m_size = int'(cfg_wdata[2:0]);
        else if (cfg_addr == 17) m_base = int'(cfg_wdata) % 4096;
        else if (cfg_addr == 18) m_thr = int'(cfg_wdata);
      end
    end
  end

  always @(negedge clk) begin
    if (!rst && !done) begin
      bit ew;
      ew = (m_aq.size() != 0);
      chk("R3", "ram_we", int'(ram_we), int'(ew));
      chk("R7", "busy", int'(busy), int'(ew));
      if (ew && ram_we) begin
        chk("R2", "ram_addr", int'(ram_addr), m_aq[0]);
        chk("R3", "ram_wdata", int'(ram_wdata), m_dq[0]);
      end
      chk("R8", "irq", int'(irq), int'(m_irq));
      chk("R5", "drop_flag", int'(drop_flag), int'(m_drop));
      chk("R6", "miss_flag", int'(miss_flag), int'(m_miss));
      if (irq) irq_seen++;
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !done) begin
      done = 1;
      checks++; failures++;
      $display("FAIL watchdog expired act=%0d exp=0", cyc);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  task automatic do_reset();
    @(negedge clk); rst = 1;
    repeat (2) @(negedge clk);
    rst = 0;
  endtask

  task automatic cfg(input int a, input int d);
    @(negedge clk);
    cfg_we = 1; cfg_addr = 5'(a); cfg_wdata = 16'(d);
    @(negedge clk);
    cfg_we = 0;
  endtask

  function automatic logic [127:0] mk_words(input int f, input int s);
    logic [127:0] v;
    for (int w = 0; w < 8; w++) v[w*16 +: 16] = 16'((f << 12) ^ (s << 4) ^ (w * 37 + 5));
    return v;
  endfunction

  task automatic send(input int f);
    @(negedge clk);
    msg_valid = 1; msg_filter = 4'(f); msg_words = mk_words(f, seqn); seqn++;
    @(negedge clk);
    msg_valid = 0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    // R1: reset state
    scen = "R1";
    idle(3);
    rst = 0;
    chk("R1", "ram_we", int'(ram_we), 0);
    chk("R1", "busy", int'(busy), 0);
    chk("R1", "irq", int'(irq), 0);
    chk("R1", "drop_flag", int'(drop_flag), 0);
    chk("R1", "miss_flag", int'(miss_flag), 0);
    // R1: default pointer 0, base 0 -> buffer 0 at address 0
    send(9);
    chk("R1", "first addr", int'(ram_addr), 0);
    idle(10);

    // R2 / R3: pointer steering with count 16
    scen = "R2";
    cfg(16, 4);
    cfg(17, 12'h100);
    for (int f = 0; f < 16; f++) cfg(f, (f * 7 + 3) % 16);
    for (int f = 0; f < 16; f += 3) begin send(f); idle(9); end
    send(1);
    chk("R2", "filter 1 start", int'(ram_addr), 12'h100 + 8 * 10);
    idle(9);

    // R6: collision with a message in flight
    scen = "R6";
    @(negedge clk);
    msg_valid = 1; msg_filter = 4'd2; msg_words = mk_words(2, seqn); seqn++;
    @(negedge clk);
    msg_filter = 4'd5; msg_words = mk_words(5, seqn); seqn++;
    @(negedge clk);
    msg_valid = 0;
    idle(5);
    // Match on the last write cycle is also ignored
    send(4);
    idle(6);
    @(negedge clk); msg_valid = 1; msg_filter = 4'd6;
    @(negedge clk); msg_valid = 0;
    idle(10);
    chk("R6", "miss sticky", int'(miss_flag), 1);

    // R10: configuration changes while busy
    scen = "R10";
    send(3);
    cfg(3, 0);
    cfg(17, 12'h040);
    idle(8);
    send(3);
    chk("R10", "new target", int'(ram_addr), 12'h040);
    idle(9);

    // R4 / R5: count code boundaries
    scen = "R4";
    do_reset();
    for (int code = 0; code < 8; code++) begin
      int lim;
      lim = sizes[code];
      cfg(16, code);
      cfg(0, lim > 15 ? 15 : lim - 1);
      cfg(1, lim > 15 ? 15 : lim);
      send(0);
      idle(9);
      if (lim <= 15) begin
        do_reset();
        cfg(16, code);
        cfg(1, lim);
        send(1);
        chk("R5", "no write on drop", int'(ram_we), 0);
        idle(2);
        chk("R4", "drop at count", int'(drop_flag), 1);
        do_reset();
      end
    end
    cfg(16, 7);
    cfg(2, 15);
    send(2);
    idle(9);
    chk("R4", "code 111 accepts 15", int'(drop_flag), 0);

    // R8: interrupt thresholds
    scen = "R8";
    do_reset();
    cfg(18, 8);
    irq_seen = 0;
    send(0); idle(9); send(4); idle(9);
    chk("R8", "pulses at 8", irq_seen, 2);
    cfg(18, 3);
    irq_seen = 0;
    send(1); idle(9); send(2); idle(9);
    chk("R8", "pulses at 3", irq_seen, 5);
    cfg(18, 1);
    irq_seen = 0;
    send(3); idle(10);
    chk("R8", "pulses at 1", irq_seen, 8);

    // R9: threshold zero
    scen = "R9";
    cfg(18, 0);
    irq_seen = 0;
    send(5); idle(9); send(6); idle(9);
    chk("R9", "no pulses", irq_seen, 0);
    cfg(18, 5);
    irq_seen = 0;
    send(7); idle(10);
    chk("R9", "counter restarted", irq_seen, 1);

    // R11: wrap at top of address space
    scen = "R11";
    do_reset();
    cfg(17, 12'hFFC);
    cfg(4, 0);
    send(4);
    idle(4);
    chk("R11", "wrapped addr", int'(ram_addr), 0);
    idle(6);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule